// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block decides which of six interrupt sources an 8-bit controller core services next. The sources are two external lines, three timer lines and one serial line; the serial request is formed by OR-ing the receive and transmit flags. Software reaches two byte-wide registers over a small register bus. One register holds a master gate and a per-source enable. The other register places each source in either the low or the high priority class.

A machine-cycle strobe captures the request flags into a sample register. When the core signals an instruction boundary, the arbiter selects the best eligible sampled request. It then issues a one-cycle acknowledge carrying a 16-bit vector address and the priority class of the winner. Two in-service bits, one per class, record which classes have an active handler. Only a request in a strictly higher class may interrupt a running handler. A return strobe from the core releases the high class first, and the low class only when the high class is not in service.

Top module: `irq_arb_top`

## Requirements
- R1: After reset, both registers read 00h, `ack_o` is 0 and `in_service_o` is 2'b00.
- R2: The enable register is at address A8h. Bit 7 is the master gate. Bits 5..0 enable sources 5..0. Bit 6 always reads 0, and writes to bit 6 are ignored.
- R3: The priority register is at address B8h. Bits 5..0 set the class of sources 5..0, where 1 means high. Bits 7..6 read 0. Any other address reads 00h.
- R4: Request flags are captured only in a cycle where `mcycle_i` is 1. A flag change without that strobe is not seen. A captured flag stays pending whether or not its source is enabled.
- R5: At the clock edge where `boundary_i` is 1 and an eligible request exists, the arbiter drives `ack_o` high for the following cycle. In that same cycle it drives the winner's vector on `ack_vec_o` and the winner's class on `ack_level_o`.
- R6: Source indices are ext0=0, timer0=1, ext1=2, timer1=3, serial=4 and timer2=5. Each vector is 0003h + 8 × index, which gives 0003h, 000Bh, 0013h, 001Bh, 0023h and 002Bh.
- R7: Inside one priority class, the lower source index wins.
- R8: A high-class request wins over any low-class request, regardless of source index.
- R9: While the master gate is 0, no acknowledge is issued.
- R10: A high-class request is eligible only while the high class is not in service. A low-class request is eligible only while neither class is in service.
- R11: An acknowledge sets the in-service bit of the winner's class. A `reti_i` pulse clears the high bit if it is set, and clears the low bit otherwise.
- R12: The serial source requests when either `ser_rx_i` or `ser_tx_i` is captured high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | 2 | External request flags, bit 0 = ext0, bit 1 = ext1 |
| tmr_req_i | input | 3 | Timer request flags, bit n = timer n |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| mcycle_i | input | 1 | Machine-cycle sampling strobe |
| boundary_i | input | 1 | Instruction boundary, acknowledge window |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reg_addr_i | input | 8 | Register address |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| ack_o | output | 1 | Acknowledge pulse |
| ack_vec_o | output | 16 | Vector address of the acknowledged source |
| ack_level_o | output | 1 | Class of the acknowledged source, 1 = high |
| in_service_o | output | 2 | In-service bits, bit 1 = high class, bit 0 = low class |

## Verification
The selection logic is tested with four kinds of request pattern:
- A single flag per source checks the vector computation for each source.
- All six flags raised at once, all in the low class, and drained one at a time checks the fixed order inside a class.
- Mixed classes show that a high-class request beats a lower-indexed low-class one.
- Requests raised while a handler is running show which class combinations are blocked and which preempt.

Separate sequences cover three more cases. A flag toggled without the sampling strobe must not be seen. A flag captured while its source is disabled or the master gate is off must stay pending. Back-to-back returns must release the high class before the low class.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned SRC_W   = 3;
  localparam int unsigned VEC_W   = 16;

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  typedef struct packed {
    logic             valid;
    logic             hi;
    logic [SRC_W-1:0] idx;
  } pick_t;

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx,
                                              input int unsigned base,
                                              input int unsigned stride);
    return VEC_W'(base + stride * int'(idx));
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 8,
  parameter int unsigned      DATA_W   = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'hA8,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 8'hB8,
  parameter int unsigned      GATE_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              gate_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] hi_o
);
  logic               gate_q;
  logic [NUM_SRC-1:0] en_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      en_q   <= '0;
      hi_q   <= '0;
    end else if (we_i) begin
      if (addr_i == EN_ADDR) begin
        gate_q <= wdata_i[GATE_BIT];
        en_q   <= wdata_i[NUM_SRC-1:0];
      end
      if (addr_i == PRI_ADDR) hi_q <= wdata_i[NUM_SRC-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == EN_ADDR) begin
      rdata_o[NUM_SRC-1:0] = en_q;
      rdata_o[GATE_BIT]    = gate_q;
    end else if (addr_i == PRI_ADDR) begin
      rdata_o[NUM_SRC-1:0] = hi_q;
    end
  end

  assign gate_o = gate_q;
  assign en_o   = en_q;
  assign hi_o   = hi_q;

  // R3: priority writes never disturb the enable side
  a_r3_pri_wr_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == PRI_ADDR && PRI_ADDR != EN_ADDR) |=> $stable(en_q) && $stable(gate_q));
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] samp_o
);
  logic [WIDTH-1:0] samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       samp_q <= '0;
    else if (strobe_i) samp_q <= raw_i;
  end

  assign samp_o = samp_q;

  // R4: sample only moves on the strobe
  a_r4_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(samp_q));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] hi_i,
  input  logic               gate_i,
  input  logic [1:0]         isr_i,
  output pick_t              pick_o
);
  logic [NUM_SRC-1:0] hi_cand, lo_cand;
  logic               hi_ok, lo_ok;

  assign hi_ok = gate_i & ~isr_i[1];
  assign lo_ok = gate_i & ~isr_i[1] & ~isr_i[0];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
    assign hi_cand[g] = pend_i[g] & en_i[g] &  hi_i[g] & hi_ok;
    assign lo_cand[g] = pend_i[g] & en_i[g] & ~hi_i[g] & lo_ok;
  end

  logic             hi_any, lo_any;
  logic [SRC_W-1:0] hi_idx, lo_idx;

  // descending scan: lowest index wins
  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hi_cand[i]) begin
        hi_any = 1'b1;
        hi_idx = SRC_W'(i);
      end
      if (lo_cand[i]) begin
        lo_any = 1'b1;
        lo_idx = SRC_W'(i);
      end
    end
  end

  always_comb begin
    pick_o.valid = hi_any | lo_any;
    pick_o.hi    = hi_any;
    pick_o.idx   = hi_any ? hi_idx : lo_idx;
  end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_i,
  input  logic       ack_hi_i,
  input  logic       reti_i,
  output logic [1:0] isr_o
);
  logic [1:0] isr_q, isr_d;

  always_comb begin
    isr_d = isr_q;
    if (reti_i) begin
      if (isr_d[1]) isr_d[1] = 1'b0;
      else          isr_d[0] = 1'b0;
    end
    if (ack_i) begin
      if (ack_hi_i) isr_d[1] = 1'b1;
      else          isr_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= 2'b00;
    else         isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  // R11: return with both active drops only the high class
  a_r11_reti_high_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && isr_q == 2'b11) |=> isr_q == 2'b01);
  // R11: acknowledge marks its class
  a_r11_ack_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_hi_i) |=> isr_q[1]);
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  ext_req_i,
  input  logic [2:0]  tmr_req_i,
  input  logic        ser_rx_i,
  input  logic        ser_tx_i,
  input  logic        mcycle_i,
  input  logic        boundary_i,
  input  logic        reti_i,
  input  logic [7:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        ack_o,
  output logic [15:0] ack_vec_o,
  output logic        ack_level_o,
  output logic [1:0]  in_service_o
);
  logic [NUM_SRC-1:0] raw, pend, en, hi;
  logic               gate;
  logic [1:0]         isr;
  pick_t              pick;
  logic               take;

  // order fixes the in-class ranking
  assign raw[SRC_EXT0] = ext_req_i[0];
  assign raw[SRC_TMR0] = tmr_req_i[0];
  assign raw[SRC_EXT1] = ext_req_i[1];
  assign raw[SRC_TMR1] = tmr_req_i[1];
  assign raw[SRC_SER]  = ser_rx_i | ser_tx_i;
  assign raw[SRC_TMR2] = tmr_req_i[2];

  irq_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .gate_o  (gate),
    .en_o    (en),
    .hi_o    (hi)
  );

  irq_sampler #(.WIDTH(NUM_SRC)) u_samp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (mcycle_i),
    .raw_i    (raw),
    .samp_o   (pend)
  );

  irq_select u_sel (
    .pend_i (pend),
    .en_i   (en),
    .hi_i   (hi),
    .gate_i (gate),
    .isr_i  (isr),
    .pick_o (pick)
  );

  assign take = boundary_i & pick.valid;

  irq_nest_track u_nest (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ack_i    (take),
    .ack_hi_i (pick.hi),
    .reti_i   (reti_i),
    .isr_o    (isr)
  );

  logic        ack_q, lvl_q;
  logic [15:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      lvl_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= take;
      if (take) begin
        lvl_q <= pick.hi;
        vec_q <= vec_of(pick.idx, VEC_BASE, VEC_STRIDE);
      end
    end
  end

  assign ack_o        = ack_q;
  assign ack_vec_o    = vec_q;
  assign ack_level_o  = lvl_q;
  assign in_service_o = isr;

  // R5: acknowledge only follows a boundary
  a_r5_ack_after_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(boundary_i));
  // R9: master gate off blocks acknowledge
  a_r9_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !gate) |=> !ack_o);
  // R10: high class in service blocks everything
  a_r10_high_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && isr[1]) |=> !ack_o);
  // R10: low class in service admits only high class
  a_r10_low_busy_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && isr == 2'b01) |=> (!ack_o || ack_level_o));
  // R6: vector lands on a defined slot
  a_r6_vec_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (ack_vec_o[2:0] == 3'd3 && ack_vec_o <= 16'h002B));
endmodule

// File: tb/irq_arb_top_tb_top.sv
`timescale 1ns/1ps
module irq_arb_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ext_req_i = '0;
  logic [2:0]  tmr_req_i = '0;
  logic        ser_rx_i = 1'b0, ser_tx_i = 1'b0;
  logic        mcycle_i = 1'b0, boundary_i = 1'b0, reti_i = 1'b0;
  logic [7:0]  reg_addr_i = '0, reg_wdata_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_rdata_o;
  logic        ack_o, ack_level_o;
  logic [15:0] ack_vec_o;
  logic [1:0]  in_service_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_arb_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_req_i(ext_req_i), .tmr_req_i(tmr_req_i),
    .ser_rx_i(ser_rx_i), .ser_tx_i(ser_tx_i), .mcycle_i(mcycle_i),
    .boundary_i(boundary_i), .reti_i(reti_i), .reg_addr_i(reg_addr_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .ack_o(ack_o), .ack_vec_o(ack_vec_o), .ack_level_o(ack_level_o),
    .in_service_o(in_service_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  // bit order: ext0,tmr0,ext1,tmr1,ser(rx),tmr2
  task automatic put_src(input logic [5:0] b, input logic tx);
    ext_req_i = {b[2], b[0]};
    tmr_req_i = {b[5], b[3], b[1]};
    ser_rx_i  = b[4];
    ser_tx_i  = tx;
  endtask

  task automatic sample(input logic [5:0] b, input logic tx);
    @(negedge clk_i);
    put_src(b, tx);
    mcycle_i = 1'b1;
    @(negedge clk_i);
    mcycle_i = 1'b0;
  endtask

  task automatic try_ack(input bit exp_ack, input logic [15:0] exp_vec,
                         input logic exp_lvl, input string tag);
    @(negedge clk_i);
    boundary_i = 1'b1;
    @(negedge clk_i);
    boundary_i = 1'b0;
    chk(ack_o == exp_ack, {tag, " ack"}, ack_o, exp_ack);
    if (exp_ack) begin
      chk(ack_vec_o == exp_vec, {tag, " vec"}, ack_vec_o, exp_vec);
      chk(ack_level_o == exp_lvl, {tag, " lvl"}, ack_level_o, exp_lvl);
    end
  endtask

  task automatic reti_pulse();
    @(negedge clk_i);
    reti_i = 1'b1;
    @(negedge clk_i);
    reti_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(ack_o == 1'b0, "R1 ack", ack_o, 0);
    chk(in_service_o == 2'b00, "R1 isr", in_service_o, 0);
    rd_chk(8'hA8, 8'h00, "R1 en reg");
    rd_chk(8'hB8, 8'h00, "R1 pri reg");
  endtask

  task automatic t_regs();
    wr(8'hA8, 8'hFF);
    rd_chk(8'hA8, 8'hBF, "R2 en reg bit6 dropped");
    wr(8'hA8, 8'h15);
    rd_chk(8'hA8, 8'h15, "R2 en reg pattern");
    wr(8'hB8, 8'hFF);
    rd_chk(8'hB8, 8'h3F, "R3 pri reg top bits");
    rd_chk(8'h10, 8'h00, "R3 unmapped addr");
    wr(8'hB8, 8'h00);
    wr(8'hA8, 8'h00);
  endtask

  task automatic t_sample_gate();
    wr(8'hA8, 8'hBF);
    @(negedge clk_i);
    put_src(6'b000001, 1'b0);   // no strobe
    try_ack(1'b0, 16'h0, 1'b0, "R4 no strobe");
    sample(6'b000001, 1'b0);
    try_ack(1'b1, 16'h0003, 1'b0, "R4 after strobe");
    sample(6'b0, 1'b0);
    reti_pulse();
  endtask

  task automatic t_gate_disabled();
    wr(8'hA8, 8'h3F);            // gate off
    sample(6'b001000, 1'b0);
    try_ack(1'b0, 16'h0, 1'b0, "R9 gate off");
    wr(8'hA8, 8'h80);            // gate on, sources off
    try_ack(1'b0, 16'h0, 1'b0, "R9 source off");
    wr(8'hA8, 8'hBF);            // flag still pending
    try_ack(1'b1, 16'h001B, 1'b0, "R4 kept while disabled");
    sample(6'b0, 1'b0);
    reti_pulse();
    chk(in_service_o == 2'b00, "R11 low release", in_service_o, 0);
  endtask

  task automatic t_vectors();
    for (int i = 0; i < 6; i++) begin
      sample(6'(1 << i), 1'b0);
      try_ack(1'b1, 16'(3 + 8 * i), 1'b0, $sformatf("R6 vec src%0d", i));
      sample(6'b0, 1'b0);
      reti_pulse();
    end
  endtask

  task automatic t_order();
    logic [5:0] f = 6'h3F;
    sample(f, 1'b0);
    for (int i = 0; i < 6; i++) begin
      try_ack(1'b1, 16'(3 + 8 * i), 1'b0, $sformatf("R7 rank %0d", i));
      f[i] = 1'b0;
      sample(f, 1'b0);
      reti_pulse();
    end
  endtask

  task automatic t_high();
    wr(8'hB8, 8'h20);            // timer2 high
    sample(6'h3F, 1'b0);
    try_ack(1'b1, 16'h002B, 1'b1, "R8 high wins");
    chk(in_service_o == 2'b10, "R11 high mark", in_service_o, 2);
    sample(6'b0, 1'b0);
    reti_pulse();
    wr(8'hB8, 8'h00);
  endtask

  task automatic t_nest();
    sample(6'b000001, 1'b0);
    try_ack(1'b1, 16'h0003, 1'b0, "R10 low entry");
    sample(6'b000101, 1'b0);
    try_ack(1'b0, 16'h0, 1'b0, "R10 equal blocked");
    wr(8'hB8, 8'h22);            // timer2, timer0 high
    sample(6'b100101, 1'b0);
    try_ack(1'b1, 16'h002B, 1'b1, "R10 high preempts");
    chk(in_service_o == 2'b11, "R11 both marked", in_service_o, 3);
    sample(6'b000011, 1'b0);
    try_ack(1'b0, 16'h0, 1'b0, "R10 high busy blocks high");
    sample(6'b0, 1'b0);
    reti_pulse();
    chk(in_service_o == 2'b01, "R11 high first", in_service_o, 1);
    reti_pulse();
    chk(in_service_o == 2'b00, "R11 low second", in_service_o, 0);
    wr(8'hB8, 8'h00);
  endtask

  task automatic t_serial();
    sample(6'b0, 1'b1);          // tx only
    try_ack(1'b1, 16'h0023, 1'b0, "R12 tx");
    sample(6'b0, 1'b0);
    reti_pulse();
    sample(6'b010000, 1'b1);
    try_ack(1'b1, 16'h0023, 1'b0, "R12 rx and tx");
    sample(6'b0, 1'b0);
    reti_pulse();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_sample_gate();
    t_gate_disabled();
    t_vectors();
    t_order();
    t_high();
    t_nest();
    t_serial();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule